// File: doc/BRIEF.md
# Galois LFSR Key Sequencer

This block produces a 56-bit key on every clock for a downstream pipeline that tests one candidate key per cycle. Instead of a binary counter, whose carry chain would be long at this width, it multiplies the current key by x modulo the primitive polynomial x^56 + x^7 + x^4 + x^2 + 1. Every step is then a one-bit left shift. The feedback XOR reaches only the lowest byte, so the next-state logic of each flop is at most one XOR deep. Started from any non-zero value, the sequence walks through all 2^56 - 1 non-zero keys before it repeats.

A host loads a start key one byte at a time while the block is halted, then releases the halt. From then on the key advances once per clock. The zero key is a fixed point of the sequence, so the host has to test it by some other means. Reset clears the key to zero, which means a start key must be loaded before the block is released.

Top module: `galois_key_stepper`

## Requirements
- R1: While `haltIn` is 0, each rising clock edge replaces the key k with k·x mod g, where g = x^56+x^7+x^4+x^2+1. The key shifts left one bit, and if the bit that leaves bit 55 was 1, then the value 0x95 (bits 7, 4, 2 and 0) is XORed into the new key. Starting from key 1, the key is 0x95 after exactly 56 steps.
- R2: Feedback affects only key bits 7..0. Each higher byte b (bits 8b+7..8b) shifts left and takes bit 7 of byte b-1 into its bit 0. Key 0x80 steps to 0x100, and key 0x80_0000_0000_0000 steps to 0x95.
- R3: While `haltIn` is 1 and `wrEn` is 0, the key keeps its value on every clock.
- R4: While `haltIn` is 1 and `wrEn` is 1, with `wrIdx` = i and i in 0..6, key bits 8i+7..8i take `wrData` at the clock edge and all other key bits keep their values.
- R5: While `haltIn` is 1 and `wrEn` is 1 with `wrIdx` = 7, the whole key keeps its value.
- R6: While `haltIn` is 0, `wrEn`, `wrIdx` and `wrData` have no effect, and the key follows R1 only.
- R7: An all-zero key stays all-zero while the block steps.
- R8: While `rstN` is 0, the key is all-zero.
- R9: From a non-zero start key, stepping never produces zero and does not return to the start key within the first several thousand steps.
- R10: `keyOut` is the key register itself. A step or a byte load is visible on `keyOut` after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| haltIn | input | 1 | 1 = hold the key and accept byte loads, 0 = step once per clock |
| wrEn | input | 1 | Byte load strobe, only acted on while halted |
| wrIdx | input | 3 | Byte select, 0 = least significant byte, 7 = no byte |
| wrData | input | 8 | Byte value to load |
| keyOut | output | 56 | Current key |

## Verification
The properties assume that `haltIn`, `wrEn`, `wrIdx` and `wrData` are synchronous to `clk` and stable around the rising edge, and that nothing is known about the key before reset. The bench meets these conditions by changing every input only on the falling edge and by holding reset asserted over several edges before the first load. The stimulus loads keys only while halted, except in one deliberate phase where writes are driven while the block steps to show that they are ignored. Zero keys are used on purpose only in the phase that checks the fixed point.

// File: rtl/gks_pkg.sv
package gks_pkg;
  localparam int unsigned IDX_BITS   = 3;
  localparam int unsigned BYTE_BITS  = 8;
  localparam int unsigned KEY_BYTES  = 7;
  localparam logic [BYTE_BITS-1:0] POLY_LOW = 8'h95;

  typedef struct packed {
    logic                advance;
    logic                loadAny;
    logic [IDX_BITS-1:0] loadIdx;
  } stepCtrl_t;
endpackage

// File: rtl/gks_ctrl.sv
module gks_ctrl #(
  parameter int unsigned NUM_BYTES = gks_pkg::KEY_BYTES
) (
  input  logic                         haltIn,
  input  logic                         wrEn,
  input  logic [gks_pkg::IDX_BITS-1:0] wrIdx,
  output gks_pkg::stepCtrl_t           ctrl
);
  localparam int unsigned CMP_W = gks_pkg::IDX_BITS + 1;
  localparam logic [CMP_W-1:0] BYTE_LIMIT = CMP_W'(NUM_BYTES);

  logic idxInRange;

  assign idxInRange = ({1'b0, wrIdx} < BYTE_LIMIT);

  always_comb begin
    ctrl.advance = ~haltIn;
    ctrl.loadAny = haltIn & wrEn & idxInRange;
    ctrl.loadIdx = wrIdx;
  end
endmodule

// File: rtl/gks_byte_stage.sv
module gks_byte_stage #(
  parameter int unsigned     BYTE_W   = gks_pkg::BYTE_BITS,
  parameter bit              IS_POLY  = 1'b0,
  parameter logic [BYTE_W-1:0] TAP_MASK = gks_pkg::POLY_LOW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              load,
  input  logic [BYTE_W-1:0] loadData,
  input  logic              shiftIn,
  output logic [BYTE_W-1:0] q,
  output logic              carryOut
);
  logic [BYTE_W-1:0] shifted;

  generate
    if (IS_POLY) begin : g_poly
      assign shifted = {q[BYTE_W-2:0], 1'b0} ^ (shiftIn ? TAP_MASK : '0);
    end else begin : g_plain
      assign shifted = {q[BYTE_W-2:0], shiftIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0;
    end else if (advance) begin
      q <= shifted;
    end else if (load) begin
      q <= loadData;
    end
  end

  assign carryOut = q[BYTE_W-1];
endmodule

// File: rtl/gks_datapath.sv
module gks_datapath #(
  parameter int unsigned       BYTE_W    = gks_pkg::BYTE_BITS,
  parameter int unsigned       NUM_BYTES = gks_pkg::KEY_BYTES,
  parameter logic [BYTE_W-1:0] TAP_MASK  = gks_pkg::POLY_LOW,
  localparam int unsigned      KEY_W     = BYTE_W * NUM_BYTES
) (
  input  logic               clk,
  input  logic               rstN,
  input  gks_pkg::stepCtrl_t ctrl,
  input  logic [BYTE_W-1:0]  wrData,
  output logic [KEY_W-1:0]   keyOut
);
  logic [NUM_BYTES-1:0] carry;

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic loadSel;
      logic shiftIn;
      assign loadSel = ctrl.loadAny &&
                       (ctrl.loadIdx == gks_pkg::IDX_BITS'(b));
      if (b == 0) begin : g_low
        assign shiftIn = carry[NUM_BYTES-1];
      end else begin : g_high
        assign shiftIn = carry[b-1];
      end
      gks_byte_stage #(
        .BYTE_W  (BYTE_W),
        .IS_POLY (b == 0),
        .TAP_MASK(TAP_MASK)
      ) u_stage (
        .clk     (clk),
        .rstN    (rstN),
        .advance (ctrl.advance),
        .load    (loadSel),
        .loadData(wrData),
        .shiftIn (shiftIn),
        .q       (keyOut[b*BYTE_W +: BYTE_W]),
        .carryOut(carry[b])
      );
    end
  endgenerate
endmodule

// File: rtl/galois_key_stepper.sv
module galois_key_stepper #(
  parameter int unsigned       BYTE_W    = gks_pkg::BYTE_BITS,
  parameter int unsigned       NUM_BYTES = gks_pkg::KEY_BYTES,
  parameter logic [BYTE_W-1:0] TAP_MASK  = gks_pkg::POLY_LOW,
  localparam int unsigned      KEY_W     = BYTE_W * NUM_BYTES,
  localparam int unsigned      IDX_W     = gks_pkg::IDX_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltIn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BYTE_W-1:0] wrData,
  output logic [KEY_W-1:0]  keyOut
);
  gks_pkg::stepCtrl_t ctrl;

  gks_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .haltIn(haltIn),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .ctrl  (ctrl)
  );

  gks_datapath #(
    .BYTE_W   (BYTE_W),
    .NUM_BYTES(NUM_BYTES),
    .TAP_MASK (TAP_MASK)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .wrData(wrData),
    .keyOut(keyOut)
  );
endmodule

// File: rtl/gks_checker.sv
module gks_checker #(
  parameter int unsigned       BYTE_W    = 8,
  parameter int unsigned       NUM_BYTES = 7,
  parameter logic [BYTE_W-1:0] TAP_MASK  = 8'h95,
  localparam int unsigned      KEY_W     = BYTE_W * NUM_BYTES
) (
  input logic              clk,
  input logic              rstN,
  input logic              haltIn,
  input logic              wrEn,
  input logic [2:0]        wrIdx,
  input logic [BYTE_W-1:0] wrData,
  input logic [KEY_W-1:0]  keyOut
);
  function automatic logic [KEY_W-1:0] timesX(input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] low;
    low = {{(KEY_W-BYTE_W){1'b0}}, TAP_MASK};
    return {k[KEY_W-2:0], 1'b0} ^ (k[KEY_W-1] ? low : '0);
  endfunction

  // R1, R6, R10: while running, the key is the previous key times x
  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    !haltIn |=> keyOut == timesX($past(keyOut)));

  // R3: halted with no write holds the key
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (haltIn && !wrEn) |=> $stable(keyOut));

  // R5: byte index 7 changes nothing
  a_r5_idx7_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (haltIn && wrEn && wrIdx == 3'd7) |=> $stable(keyOut));

  // R7: zero is a fixed point
  a_r7_zero_stays: assert property (@(posedge clk) disable iff (!rstN)
    (!haltIn && keyOut == '0) |=> keyOut == '0);

  // R9: a non-zero key never steps to zero
  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!haltIn && keyOut != '0) |=> keyOut != '0);

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_ld
      localparam logic [KEY_W-1:0] MASK =
        {{(KEY_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << (b * BYTE_W);
      // R4: selected byte loads, others hold
      a_r4_byte_load: assert property (@(posedge clk) disable iff (!rstN)
        (haltIn && wrEn && wrIdx == 3'(b)) |=>
          (keyOut[b*BYTE_W +: BYTE_W] == $past(wrData)) &&
          ((keyOut & ~MASK) == ($past(keyOut) & ~MASK)));
    end
  endgenerate

  // R8: reset value
  always @(negedge clk) begin
    if (!rstN) begin
      a_r8_reset_zero: assert (keyOut == '0);
    end
  end
endmodule

bind galois_key_stepper gks_checker #(
  .BYTE_W   (BYTE_W),
  .NUM_BYTES(NUM_BYTES),
  .TAP_MASK (TAP_MASK)
) u_gks_checker (
  .clk   (clk),
  .rstN  (rstN),
  .haltIn(haltIn),
  .wrEn  (wrEn),
  .wrIdx (wrIdx),
  .wrData(wrData),
  .keyOut(keyOut)
);

// File: tb/galois_key_stepper_bench.sv
`timescale 1ns/1ps
module galois_key_stepper_bench;
  localparam int KEY_W = 56;
  localparam logic [KEY_W-1:0] LOW_POLY = 56'h95;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltIn = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [KEY_W-1:0] keyOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string curReq = "R8";
  logic [KEY_W-1:0] model;

  galois_key_stepper u_galois_key_stepper (
    .clk(clk), .rstN(rstN), .haltIn(haltIn), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .keyOut(keyOut)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: polynomial multiply by x, byte loads when halted
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      model <= '0;
    end else if (!haltIn) begin
      if (model[KEY_W-1]) model <= (model << 1) ^ LOW_POLY;
      else                model <= model << 1;
    end else if (wrEn && wrIdx < 3'd7) begin
      model[int'(wrIdx)*8 +: 8] <= wrData;
    end
  end

  task automatic check(input string req, input logic [KEY_W-1:0] act,
                       input logic [KEY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %014h expected %014h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R10 timing)
  always @(negedge clk) begin
    if (rstN && !finished) check({curReq, " R10"}, keyOut, model);
  end

  task automatic wr(input int idx, input logic [7:0] d);
    haltIn = 1'b1; wrEn = 1'b1; wrIdx = 3'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadKey(input logic [KEY_W-1:0] k);
    for (int i = 0; i < 7; i++) wr(i, k[i*8 +: 8]);
  endtask

  task automatic run(input int n);
    haltIn = 1'b0;
    repeat (n) @(negedge clk);
    haltIn = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    summary();
  end

  initial begin
    logic [KEY_W-1:0] seed;
    logic [KEY_W-1:0] snap;
    bit bad;
    repeat (3) @(negedge clk);
    check("R8", keyOut, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: zero key stays zero while stepping
    curReq = "R7";
    run(8);
    check("R7", keyOut, '0);

    // R4: byte loads
    curReq = "R4";
    wr(0, 8'h01);
    check("R4", keyOut, 56'h1);
    wr(3, 8'hA5);
    check("R4", keyOut, 56'h00_0000_A500_0001);
    wr(6, 8'h3C);
    check("R4", keyOut, 56'h3C_0000_A500_0001);

    // R5: index 7 ignored
    curReq = "R5";
    wr(7, 8'hFF);
    check("R5", keyOut, 56'h3C_0000_A500_0001);

    // R3: halted hold
    curReq = "R3";
    repeat (6) @(negedge clk);
    check("R3", keyOut, 56'h3C_0000_A500_0001);

    // R1: 1 times x^56 = 0x95
    curReq = "R1";
    loadKey(56'h1);
    check("R4", keyOut, 56'h1);
    run(56);
    check("R1", keyOut, 56'h95);
    run(1);
    check("R1", keyOut, 56'h12A);

    // R2: carry across bytes and feedback from bit 55
    curReq = "R2";
    loadKey(56'h80);
    run(1);
    check("R2", keyOut, 56'h100);
    loadKey(56'h80_0000_0000_0000);
    run(1);
    check("R2", keyOut, 56'h95);
    loadKey(56'h00_8000_0000_8080);
    run(1);
    check("R2", keyOut, 56'h01_0000_0001_0100);

    // R6: writes while running are ignored
    curReq = "R6";
    loadKey(56'h12_3456_789A_BCDE);
    haltIn = 1'b0;
    for (int i = 0; i < 20; i++) begin
      wrEn = 1'b1; wrIdx = 3'(i % 8); wrData = 8'(i * 37);
      @(negedge clk);
    end
    wrEn = 1'b0;
    haltIn = 1'b1;
    snap = 56'h12_3456_789A_BCDE;
    for (int i = 0; i < 20; i++)
      snap = snap[KEY_W-1] ? ((snap << 1) ^ LOW_POLY) : (snap << 1);
    check("R6", keyOut, snap);

    // R9: long run never hits zero nor the start key
    curReq = "R9";
    seed = 56'hC0_FFEE_0102_0304;
    loadKey(seed);
    bad = 1'b0;
    haltIn = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (keyOut == '0 || keyOut == seed) bad = 1'b1;
    end
    haltIn = 1'b1;
    check("R9", {55'd0, bad}, '0);

    @(negedge clk);
    finished = 1'b1;
    summary();
  end
endmodule